// File: doc/BRIEF.md
# Dual Mode Programmable Flag FIFO

A first-in first-out buffer that sits between two unrelated clock domains. Words enter on the write clock and leave on the read clock. Each side has a low-active enable and a low-active select, and both must be low for a transfer. Depth and word width are parameters. Two offset inputs set where the almost-empty and almost-full indications switch.

The `fallThru` input picks a timing mode. It is sampled only while the master reset is held low. In standard mode, `rdStatus` acts as an empty flag and every word, the first included, has to be requested. In fall-through mode, `rdStatus` means output-ready, and the oldest stored word is presented on `rdData` with no request. On the write side, `wrStatus` is the full flag in standard mode and input-ready in fall-through mode. It is high whenever there is room in the storage array.

Pointers pass between the domains as Gray code through two-flop synchronizers. A flag computed in one domain can therefore lag activity in the other domain. The lag only ever makes the flag more cautious, never less.

Top module: `dual_mode_fifo`

## Requirements
- R1: The mode is captured from `fallThru` on read-clock edges while `mrstN` is low (0 = standard, 1 = fall-through). After reset is released, changes on `fallThru` have no effect until the next reset.
- R2: A word is stored on a `wrClk` rising edge only when `wrEnN` and `wrCsN` are both low and `wrStatus` is high. With either of them high, nothing is stored.
- R3: In standard mode, `rdStatus` (empty flag, 0 = empty) is low after reset. After the first write into an empty queue, it still reads low after the second `rdClk` rising edge and reads high after the third.
- R4: In standard mode, a read needs `rdEnN` and `rdCsN` both low on a `rdClk` edge while `rdStatus` is high. The next word, in write order, appears on `rdData` after that edge.
- R5: In standard mode, a read request while `rdStatus` is low is ignored, and `rdData` keeps its last value.
- R6: In fall-through mode, the first word written into an empty queue appears on `rdData`, and `rdStatus` (output-ready) rises, after the third `rdClk` rising edge, with no read request. Each later word needs a read. Reading the last word drops `rdStatus` low.
- R7: `almostEmpty` is high when the stored word count is at least `emptyOff`+1, and low otherwise. In fall-through mode, the count includes the word held on the output.
- R8: `almostFullN` is high after reset. With no reads, it goes low on the write edge that brings the count to DEPTH-`fullOff`.
- R9: `wrStatus` (full flag / input-ready) goes low on the write edge that brings the count to DEPTH. Writes attempted while it is low are dropped and never reach the read side.
- R10: Immediately after reset, `rdStatus` = 0, `wrStatus` = 1, `almostEmpty` = 0, `almostFullN` = 1 and `rdData` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| mrstN | input | 1 | Master reset, low active, synchronous in each domain |
| fallThru | input | 1 | Mode select, sampled during reset (1 = fall-through) |
| wrEnN | input | 1 | Write enable, low active |
| wrCsN | input | 1 | Write select, low active |
| wrData | input | DATA_W | Word to store |
| emptyOff | input | log2(DEPTH) | Almost-empty offset n |
| fullOff | input | log2(DEPTH) | Almost-full offset m |
| rdEnN | input | 1 | Read enable, low active |
| rdCsN | input | 1 | Read select, low active |
| rdData | output | DATA_W | Output word register |
| rdStatus | output | 1 | Empty flag (standard) or output-ready (fall-through), high = data |
| wrStatus | output | 1 | Full flag or input-ready, high = room |
| almostEmpty | output | 1 | High when count is above the empty offset |
| almostFullN | output | 1 | Low when count reaches DEPTH minus the full offset |

## Verification
The assertions assume the following about the inputs:
- DEPTH is a power of two.
- Each control input changes only in step with its own clock.
- `mrstN` is held low across several edges of both clocks and released clear of any edge.
- The offsets do not change while words are moving.

The stimulus respects all of this. The two clock periods are chosen so that their rising edges never coincide. Each side's inputs are driven on the falling edge of that side's clock. Reset is released one time unit after a read-clock falling edge, after four rising edges of each clock.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } dmfMode_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic wrStrobe;    // store wrData at wrAddr (write domain)
    logic loadStrobe;  // load output register from rdAddr (read domain)
  } dmfStrobes_t;

endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

endmodule

// File: rtl/dmf_datapath.sv
module dmf_datapath
  import dmf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  dmfStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrStrobe) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (!mrstN)                  rdData <= '0;
    else if (strobes.loadStrobe) rdData <= store[rdAddr];
  end

endmodule

// File: rtl/dmf_ctrl.sv
module dmf_ctrl
  import dmf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6,
  parameter int PTR_W  = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              fallThru,
  input  logic              wrReq,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] emptyOff,
  input  logic [ADDR_W-1:0] fullOff,
  output dmfStrobes_t       strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdStatus,
  output logic              wrStatus,
  output logic              almostEmpty,
  output logic              almostFullN
);

  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wrBin, wrGray, wrBinNext, rdGraySync, rdBinSync;
  logic [PTR_W-1:0] wrCount, wrCountNext;
  logic             fullNReg, pafNReg, wrFire;

  dmf_sync #(.W(PTR_W)) rdPtrSync (
    .clk(wrClk), .rstN(mrstN), .din(rdGray), .dout(rdGraySync)
  );

  always_comb begin
    rdBinSync   = fromGray(rdGraySync);
    wrFire      = wrReq & fullNReg;
    wrBinNext   = wrBin + PTR_W'(wrFire);
    wrCount     = wrBin - rdBinSync;
    wrCountNext = wrBinNext - rdBinSync;
  end

  always_ff @(posedge wrClk) begin
    if (!mrstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      fullNReg <= 1'b1;
      pafNReg  <= 1'b1;
    end else begin
      wrBin    <= wrBinNext;
      wrGray   <= toGray(wrBinNext);
      fullNReg <= (wrCountNext != DEPTH_P);
      pafNReg  <= (wrCountNext < (DEPTH_P - {1'b0, fullOff}));
    end
  end

  // ---------------- read domain ----------------
  dmfMode_t         modeReg;
  logic [PTR_W-1:0] rdBin, rdGray, rdBinNext, wrGraySync, wrBinSync;
  logic [PTR_W-1:0] memCountNext, occupancyNext;
  logic             emptyNReg, outValid, outValidNext, paeReg;
  logic             isFwft, memNotEmpty, popMem;

  dmf_sync #(.W(PTR_W)) wrPtrSync (
    .clk(rdClk), .rstN(mrstN), .din(wrGray), .dout(wrGraySync)
  );

  always_comb begin
    isFwft      = (modeReg == MODE_FWFT);
    wrBinSync   = fromGray(wrGraySync);
    memNotEmpty = (rdBin != wrBinSync);
    if (isFwft) begin
      popMem       = memNotEmpty & (~outValid | rdReq);
      outValidNext = popMem | (outValid & ~rdReq);
    end else begin
      popMem       = rdReq & emptyNReg;
      outValidNext = 1'b0;
    end
    rdBinNext     = rdBin + PTR_W'(popMem);
    memCountNext  = wrBinSync - rdBinNext;
    occupancyNext = memCountNext + PTR_W'(outValidNext);
  end

  always_ff @(posedge rdClk) begin
    if (!mrstN) begin
      modeReg   <= dmfMode_t'(fallThru);
      rdBin     <= '0;
      rdGray    <= '0;
      emptyNReg <= 1'b0;
      outValid  <= 1'b0;
      paeReg    <= 1'b0;
    end else begin
      rdBin     <= rdBinNext;
      rdGray    <= toGray(rdBinNext);
      emptyNReg <= (memCountNext != '0);
      outValid  <= outValidNext;
      paeReg    <= (occupancyNext > {1'b0, emptyOff});
    end
  end

  // ---------------- outputs ----------------
  assign strobes.wrStrobe   = wrFire;
  assign strobes.loadStrobe = popMem;
  assign wrAddr      = wrBin[ADDR_W-1:0];
  assign rdAddr      = rdBin[ADDR_W-1:0];
  assign rdStatus    = isFwft ? outValid : emptyNReg;
  assign wrStatus    = fullNReg;
  assign almostEmpty = paeReg;
  assign almostFullN = pafNReg;

  // ---------------- assertions ----------------
  assert_mode_held_R1: assert property (@(posedge rdClk) disable iff (!mrstN)
    $stable(modeReg));

  assert_full_blocks_write_R9: assert property (@(posedge wrClk) disable iff (!mrstN)
    !fullNReg |=> (wrBin == $past(wrBin)));

  assert_count_bound_R9: assert property (@(posedge wrClk) disable iff (!mrstN)
    wrCount <= DEPTH_P);

  assert_full_implies_almost_full_R8: assert property (@(posedge wrClk) disable iff (!mrstN)
    !fullNReg |-> !pafNReg);

  assert_empty_blocks_read_R5: assert property (@(posedge rdClk) disable iff (!mrstN)
    (!isFwft && !emptyNReg) |=> (rdBin == $past(rdBin)));

  assert_ready_only_in_fwft_R6: assert property (@(posedge rdClk) disable iff (!mrstN)
    $rose(outValid) |-> isFwft);

endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              fallThru,
  input  logic              wrEnN,
  input  logic              wrCsN,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] emptyOff,
  input  logic [ADDR_W-1:0] fullOff,
  input  logic              rdEnN,
  input  logic              rdCsN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdStatus,
  output logic              wrStatus,
  output logic              almostEmpty,
  output logic              almostFullN
);

  dmfStrobes_t       strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              wrReq, rdReq;

  assign wrReq = ~wrEnN & ~wrCsN;
  assign rdReq = ~rdEnN & ~rdCsN;

  dmf_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .fallThru(fallThru),
    .wrReq(wrReq), .rdReq(rdReq), .emptyOff(emptyOff), .fullOff(fullOff),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .rdStatus(rdStatus), .wrStatus(wrStatus),
    .almostEmpty(almostEmpty), .almostFullN(almostFullN)
  );

  dmf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) datapath (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: tb/dual_mode_fifo_test.sv
module dual_mode_fifo_test;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 64;
  localparam int AW     = 6;

  // stimulus table: bit16 = expected almostEmpty after this write (n = 7), bits 15:0 = word
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 16'h1A01}, {1'b0, 16'h2B02}, {1'b0, 16'h3C03}, {1'b0, 16'h4D04},
    {1'b0, 16'h5E05}, {1'b0, 16'h6F06}, {1'b0, 16'h7A07}, {1'b1, 16'h8B08}
  };

  logic wrClk, rdClk, mrstN, fallThru, wrEnN, wrCsN, rdEnN, rdCsN;
  logic [DATA_W-1:0] wrData, rdData;
  logic [AW-1:0] emptyOff, fullOff;
  logic rdStatus, wrStatus, almostEmpty, almostFullN;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  dual_mode_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .fallThru(fallThru),
    .wrEnN(wrEnN), .wrCsN(wrCsN), .wrData(wrData),
    .emptyOff(emptyOff), .fullOff(fullOff),
    .rdEnN(rdEnN), .rdCsN(rdCsN), .rdData(rdData),
    .rdStatus(rdStatus), .wrStatus(wrStatus),
    .almostEmpty(almostEmpty), .almostFullN(almostFullN)
  );

  // 100 MHz write clock, rising edges at multiples of 10 ns
  initial begin
    wrClk = 1'b1;
    forever #5 wrClk = ~wrClk;
  end

  // read clock, rising edges at 3 + 14k ns (never on a write edge)
  initial begin
    rdClk = 1'b0;
    #3;
    forever begin
      rdClk = 1'b1; #7;
      rdClk = 1'b0; #7;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitRd(input int n);
    repeat (n) @(negedge rdClk);
  endtask

  task automatic doReset(input logic mode);
    mrstN = 1'b0; fallThru = mode;
    wrEnN = 1'b1; wrCsN = 1'b1; rdEnN = 1'b1; rdCsN = 1'b1;
    repeat (4) @(posedge rdClk);
    repeat (4) @(posedge wrClk);
    @(negedge rdClk);
    #1 mrstN = 1'b1;
    waitRd(2);
  endtask

  // returns right after the write edge
  task automatic wrWord(input logic [DATA_W-1:0] d);
    @(negedge wrClk);
    wrData = d; wrEnN = 1'b0; wrCsN = 1'b0;
    @(posedge wrClk);
    wrEnN <= 1'b1; wrCsN <= 1'b1;
  endtask

  // returns at the falling edge after the read edge
  task automatic rdWord();
    @(negedge rdClk);
    rdEnN = 1'b0; rdCsN = 1'b0;
    @(posedge rdClk);
    rdEnN <= 1'b1; rdCsN <= 1'b1;
    @(negedge rdClk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    wrData = '0; emptyOff = 6'd7; fullOff = 6'd7;

    // ---------- standard mode ----------
    doReset(1'b0);
    chk("R10 rdStatus", rdStatus, 0);
    chk("R10 wrStatus", wrStatus, 1);
    chk("R10 almostEmpty", almostEmpty, 0);
    chk("R10 almostFullN", almostFullN, 1);
    chk("R10 rdData", rdData, 0);
    fallThru = 1'b1;  // R1: must not switch the mode

    // R2: only one of the two write controls low
    @(negedge wrClk); wrData = 16'hBAD1; wrEnN = 1'b0; wrCsN = 1'b1;
    @(negedge wrClk); wrEnN = 1'b1; wrCsN = 1'b0;
    @(negedge wrClk); wrCsN = 1'b1;
    waitRd(6);
    chk("R2 no store", rdStatus, 0);

    // R3: empty flag latency
    wrWord(VEC[0][15:0]);
    @(posedge rdClk); @(posedge rdClk); @(negedge rdClk);
    chk("R3 after 2 edges", rdStatus, 0);
    @(posedge rdClk); @(negedge rdClk);
    chk("R3 after 3 edges", rdStatus, 1);
    waitRd(3);
    chk("R1 no fall-through", rdData, 0);
    chk("R7 one word", almostEmpty, VEC[0][16]);

    // table walk: writes with almost-empty expectation
    for (int i = 1; i < 8; i++) begin
      wrWord(VEC[i][15:0]);
      waitRd(4);
      chk("R7 fill", almostEmpty, VEC[i][16]);
    end

    // read back in order
    for (int i = 0; i < 8; i++) begin
      rdWord();
      chk("R4 data", rdData, VEC[i][15:0]);
      if (i == 0) chk("R7 seven left", almostEmpty, 0);
    end
    chk("R3 empty again", rdStatus, 0);
    rdWord();
    chk("R5 hold on empty", rdData, VEC[7][15:0]);
    chk("R5 still empty", rdStatus, 0);

    // fill to full without reads
    waitRd(4);
    for (int i = 0; i < DEPTH; i++) begin
      wrWord(16'(16'h0100 + i));
      @(negedge wrClk);
      if (i == 55) chk("R8 before D-m", almostFullN, 1);
      if (i == 56) chk("R8 at D-m", almostFullN, 0);
      if (i == 62) chk("R9 before D", wrStatus, 1);
      if (i == 63) chk("R9 at D", wrStatus, 0);
    end
    wrWord(16'hDEAD);
    @(negedge wrClk);
    chk("R9 stays full", wrStatus, 0);
    waitRd(4);
    for (int i = 0; i < DEPTH; i++) begin
      rdWord();
      chk("R9 drain data", rdData, 32'(16'(16'h0100 + i)));
    end
    waitRd(6);
    chk("R9 dropped write", rdStatus, 0);
    chk("R9 last word held", rdData, 32'h013F);
    repeat (4) @(negedge wrClk);
    chk("R9 room again", wrStatus, 1);

    // ---------- fall-through mode ----------
    doReset(1'b1);
    chk("R10 fwft rdStatus", rdStatus, 0);
    chk("R10 fwft wrStatus", wrStatus, 1);
    fallThru = 1'b0;  // R1: must not switch back
    emptyOff = 6'd2;
    wrWord(16'hA0A0);
    @(posedge rdClk); @(posedge rdClk); @(negedge rdClk);
    chk("R6 not yet ready", rdStatus, 0);
    @(posedge rdClk); @(negedge rdClk);
    chk("R6 ready after 3", rdStatus, 1);
    chk("R6 R1 word shown", rdData, 32'hA0A0);
    wrWord(16'hB1B1);
    wrWord(16'hC2C2);
    waitRd(6);
    chk("R6 holds first", rdData, 32'hA0A0);
    chk("R7 fwft three", almostEmpty, 1);
    rdWord();
    chk("R6 second word", rdData, 32'hB1B1);
    chk("R7 fwft two", almostEmpty, 0);
    rdWord();
    chk("R6 third word", rdData, 32'hC2C2);
    chk("R6 still ready", rdStatus, 1);
    rdWord();
    chk("R6 drained", rdStatus, 0);

    finishRun();
  end

endmodule